// File: doc/BRIEF.md
# Quasi-Cyclic Circulant Shifter

This block sits between the message memory and the node processors of a partial-parallel decoder for quasi-cyclic LDPC codes whose base matrices have 24 columns and whose expansion factor z runs from 24 to 96. That range gives code lengths from 576 to 2304 bits. For each non-null base-matrix entry, the block takes the entry's base shift value, defined for the largest size, together with the expansion factor in use and the code type. It rescales the shift to the current z and applies that circulant to a vector of z messages. The result is a circular rotation of the active lanes.

Lanes at and above z play no part in the rotation and always leave the block as zero. A negative base entry marks a null sub-block and produces an all-zero vector. A zero entry is the identity permutation.

Data moves in and out over valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. While the output is valid but not taken, the output holds the same data and the block stops accepting input. In registered mode, input ready equals output ready, or is high when the output stage is empty. In combinational mode, input ready simply follows output ready.

Top module: `qc_circulant_shifter`

## Requirements
- R1: For every code type except the 2/3A type (the code type select is 3 bits: 0 = 1/2, 1 = 2/3A, 2 = 2/3B, 3 = 3/4A, 4 = 3/4B, 5 = 5/6), the applied shift is s = floor(p * z / 96), where p is the base value.
- R2: For code type 1 (2/3A), the applied shift is s = p mod z.
- R3: For a non-negative base entry, output lane i (for i < z) carries input lane (i + s) mod z. Lane k occupies bits [8k+7 : 8k] of the vector.
- R4: A base entry of 0 gives the identity: output lanes below z equal the input lanes below z.
- R5: A negative base entry (all ones, i.e. -1, in practice; the base field is 8-bit two's complement) gives an all-zero output vector.
- R6: Output lanes at index z and above are always zero, and input lanes at index z and above have no effect on the output.
- R7: While out_valid is high and out_ready is low, out_vec and out_valid hold steady and in_ready is low. When out_ready is high, in_ready is high.
- R8: With REG_OUT = 1, an accepted input appears on out_vec with out_valid high in the cycle after the accepting edge. With REG_OUT = 0, it appears in the same cycle and out_valid equals in_valid.
- R9: During and right after reset, out_valid is low and in_ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Block can take an input item |
| in_base | input | 8 | Base-matrix entry, two's complement; -1 is null, 0..95 is a shift |
| in_z | input | 7 | Expansion factor, 24..96 |
| in_ctype | input | 3 | Code type select |
| in_vec | input | 768 | 96 lanes of 8-bit messages |
| out_valid | output | 1 | Rotated vector present |
| out_ready | input | 1 | Downstream takes the vector |
| out_vec | output | 768 | Rotated vector, lanes at and above z are zero |

## Verification
The bench builds two copies of the block side by side, both with 96 lanes and 8-bit messages. One copy uses REG_OUT = 1 and the other uses REG_OUT = 0, so the single-cycle latency, the same-cycle path and back-pressure against a full output register are all exercised in one run. Using the full 96-lane width allows z at both ends of its range and shift values right up to z - 1. It also leaves spare lanes above small z values where garbage can be injected to show that it is ignored.

// File: rtl/qcs_pkg.sv
package qcs_pkg;

  typedef enum logic [2:0] {
    CT_HALF  = 3'd0,
    CT_2_3A  = 3'd1,
    CT_2_3B  = 3'd2,
    CT_3_4A  = 3'd3,
    CT_3_4B  = 3'd4,
    CT_5_6   = 3'd5
  } code_type_e;

endpackage

// File: rtl/qcs_shift_scaler.sv
// Rescales a base shift (defined for the largest expansion) to the current z.
module qcs_shift_scaler #(
  parameter int ZMAX = 96,
  parameter int ZMIN = 24,
  parameter int SW   = $clog2(ZMAX + 1)
) (
  input  logic [SW:0]   base,
  input  logic [SW-1:0] z,
  input  logic [2:0]    ctype,
  output logic [SW-1:0] shift,
  output logic          is_null
);
  localparam int PW   = 2 * SW;
  localparam int NSUB = (ZMAX - 1) / ZMIN;

  logic [SW-1:0] mag;
  logic [PW-1:0] prod;
  logic [SW-1:0] quot;
  logic [SW-1:0] rem;

  always_comb begin
    is_null = base[SW];
    mag     = base[SW-1:0];
    prod    = {{SW{1'b0}}, mag} * {{SW{1'b0}}, z};
    quot    = SW'(prod / PW'(ZMAX));
    // base < ZMAX and z >= ZMIN bound the quotient, so NSUB subtractions suffice
    rem     = mag;
    for (int k = 0; k < NSUB; k++) begin
      if (rem >= z) rem = rem - z;
    end
    if (is_null)
      shift = '0;
    else if (qcs_pkg::code_type_e'(ctype) == qcs_pkg::CT_2_3A)
      shift = rem;
    else
      shift = quot;
  end

endmodule

// File: rtl/qcs_lane_shifter.sv
// Logarithmic lane shifter; direction picked by parameter, vacated lanes fill with zero.
module qcs_lane_shifter #(
  parameter int LANES      = 96,
  parameter int LW         = 8,
  parameter int SW         = 7,
  parameter bit TOWARD_LOW = 1'b1
) (
  input  logic [LANES*LW-1:0] din,
  input  logic [SW-1:0]       amt,
  output logic [LANES*LW-1:0] dout
);
  localparam int DW = LANES * LW;

  logic [DW-1:0] stg [SW+1];

  assign stg[0] = din;

  for (genvar st = 0; st < SW; st++) begin : g_stage
    localparam int BITS = LW * (1 << st);
    if (TOWARD_LOW) begin : g_low
      if (BITS >= DW) begin : g_wipe
        assign stg[st+1] = amt[st] ? '0 : stg[st];
      end else begin : g_sh
        assign stg[st+1] = amt[st] ? (stg[st] >> BITS) : stg[st];
      end
    end else begin : g_high
      if (BITS >= DW) begin : g_wipe
        assign stg[st+1] = amt[st] ? '0 : stg[st];
      end else begin : g_sh
        assign stg[st+1] = amt[st] ? (stg[st] << BITS) : stg[st];
      end
    end
  end

  assign dout = stg[SW];

endmodule

// File: rtl/qcs_out_stage.sv
// Output stage: pipeline register with handshake, or a plain pass-through.
module qcs_out_stage #(
  parameter int DW      = 768,
  parameter bit REG_OUT = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  if (REG_OUT) begin : g_reg
    logic          v_q;
    logic [DW-1:0] d_q;

    assign in_ready = !v_q || out_ready;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        v_q <= 1'b0;
        d_q <= '0;
      end else if (in_ready) begin
        v_q <= in_valid;
        if (in_valid) d_q <= in_data;
      end
    end

    assign out_valid = v_q;
    assign out_data  = d_q;
  end else begin : g_comb
    assign in_ready  = out_ready;
    assign out_valid = in_valid;
    assign out_data  = in_data;
  end

endmodule

// File: rtl/qc_circulant_shifter.sv
// Scales a base-matrix shift to z and rotates the active z lanes circularly.
module qc_circulant_shifter #(
  parameter int LANES   = 96,
  parameter int ZMIN    = 24,
  parameter int LW      = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int SW      = $clog2(LANES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SW:0]         in_base,
  input  logic [SW-1:0]       in_z,
  input  logic [2:0]          in_ctype,
  input  logic [LANES*LW-1:0] in_vec,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*LW-1:0] out_vec
);
  localparam int DW = LANES * LW;

  logic [SW-1:0] shift;
  logic          is_null;
  logic [SW-1:0] wrap_amt;
  logic [DW-1:0] masked_in;
  logic [DW-1:0] part_low;
  logic [DW-1:0] part_high;
  logic [DW-1:0] joined;
  logic [DW-1:0] rotated;

  qcs_shift_scaler #(
    .ZMAX (LANES),
    .ZMIN (ZMIN),
    .SW   (SW)
  ) u_scale (
    .base    (in_base),
    .z       (in_z),
    .ctype   (in_ctype),
    .shift   (shift),
    .is_null (is_null)
  );

  // Lanes at or above z are cleared before rotating so they never wrap in.
  for (genvar i = 0; i < LANES; i++) begin : g_in_mask
    assign masked_in[i*LW +: LW] = (SW'(i) < in_z) ? in_vec[i*LW +: LW] : '0;
  end

  // Rotation = (lanes moved down by s) OR (lanes moved up by z - s).
  assign wrap_amt = in_z - shift;

  qcs_lane_shifter #(
    .LANES (LANES), .LW (LW), .SW (SW), .TOWARD_LOW (1'b1)
  ) u_down (
    .din  (masked_in),
    .amt  (shift),
    .dout (part_low)
  );

  qcs_lane_shifter #(
    .LANES (LANES), .LW (LW), .SW (SW), .TOWARD_LOW (1'b0)
  ) u_up (
    .din  (masked_in),
    .amt  (wrap_amt),
    .dout (part_high)
  );

  assign joined = part_low | part_high;

  for (genvar i = 0; i < LANES; i++) begin : g_out_mask
    assign rotated[i*LW +: LW] =
      (!is_null && (SW'(i) < in_z)) ? joined[i*LW +: LW] : '0;
  end

  qcs_out_stage #(
    .DW      (DW),
    .REG_OUT (REG_OUT)
  ) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (rotated),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_vec)
  );

endmodule

// File: rtl/qcs_checker.sv
module qcs_checker #(
  parameter int LANES   = 96,
  parameter int ZMIN    = 24,
  parameter int LW      = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int SW      = $clog2(LANES + 1)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [SW:0]         in_base,
  input logic [SW-1:0]       in_z,
  input logic [2:0]          in_ctype,
  input logic [LANES*LW-1:0] in_vec,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*LW-1:0] out_vec
);
  logic take;
  assign take = in_valid && in_ready;

  p_ready_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_ready |-> in_ready);

  if (REG_OUT) begin : g_reg
    p_hold_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_vec)));

    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> out_valid);

    p_null_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_base[SW]) |=> (out_vec == '0));

    p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (take && in_base == '0 && in_z == SW'(LANES)) |=> (out_vec == $past(in_vec)));

    p_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !in_base[SW] && in_z == SW'(LANES))
        |=> ($countones(out_vec) == $countones($past(in_vec))));
  end else begin : g_comb
    p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == in_valid);

    p_null_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_base[SW]) |-> (out_vec == '0));

    p_identity_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_base == '0 && in_z == SW'(LANES)) |-> (out_vec == in_vec));

    p_lane_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_base[SW] && in_z == SW'(LANES))
        |-> ($countones(out_vec) == $countones(in_vec)));
  end

endmodule

bind qc_circulant_shifter qcs_checker #(
  .LANES (LANES), .ZMIN (ZMIN), .LW (LW), .REG_OUT (REG_OUT), .SW (SW)
) u_qcs_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_base   (in_base),
  .in_z      (in_z),
  .in_ctype  (in_ctype),
  .in_vec    (in_vec),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_vec   (out_vec)
);

// File: tb/tb_qc_circulant_shifter.sv
`timescale 1ns/1ps
module tb_qc_circulant_shifter;
  localparam int LANES = 96;
  localparam int LW    = 8;
  localparam int SW    = 7;
  localparam int DW    = LANES * LW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [SW:0]   in_base = '0;
  logic [SW-1:0] in_z = 7'd96;
  logic [2:0]    in_ctype = 3'd0;
  logic [DW-1:0] in_vec = '0;
  logic          out_ready = 1'b1;
  logic          in_ready, out_valid;
  logic [DW-1:0] out_vec;
  logic          c_in_ready, c_out_valid;
  logic [DW-1:0] c_out_vec;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  qc_circulant_shifter #(.LANES(LANES), .LW(LW), .REG_OUT(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_z(in_z), .in_ctype(in_ctype), .in_vec(in_vec),
    .out_valid(out_valid), .out_ready(out_ready), .out_vec(out_vec));

  qc_circulant_shifter #(.LANES(LANES), .LW(LW), .REG_OUT(1'b0)) dut_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(c_in_ready),
    .in_base(in_base), .in_z(in_z), .in_ctype(in_ctype), .in_vec(in_vec),
    .out_valid(c_out_valid), .out_ready(1'b1), .out_vec(c_out_vec));

  function automatic logic [DW-1:0] model(int p, int z, int ct, logic [DW-1:0] v);
    logic [DW-1:0] r = '0;
    int s;
    if (p < 0) return r;
    s = (ct == 1) ? (p % z) : ((p * z) / 96);
    for (int i = 0; i < z; i++) r[i*LW +: LW] = v[((i + s) % z)*LW +: LW];
    return r;
  endfunction

  function automatic logic [DW-1:0] mkvec(int seed);
    logic [DW-1:0] r;
    for (int i = 0; i < LANES; i++) r[i*LW +: LW] = 8'((seed * 13 + i * 37 + 1) % 251 + 1);
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // One item through both copies, checking the same-cycle and next-cycle results.
  task automatic send(int p, int z, int ct, logic [DW-1:0] v, string req);
    logic [DW-1:0] e = model(p, z, ct, v);
    @(negedge clk);
    in_base = 8'(p); in_z = 7'(z); in_ctype = 3'(ct); in_vec = v; in_valid = 1'b1;
    #1;
    chk(c_out_valid && c_out_vec == e, req, "comb path", c_out_vec, e);
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_vec == e, req, "registered path", out_vec, e);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid in reset", DW'(out_valid), '0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", DW'(in_ready), DW'(1));
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(out_valid == 1'b0 && in_ready, "R9", "after reset", DW'(out_valid), '0);
  endtask

  task automatic t_scale_prop();
    send(95, 24, 0, mkvec(1), "R1 p95 z24");   // s = 23
    send(50, 60, 3, mkvec(2), "R1 p50 z60");   // s = 31
    send(7,  96, 5, mkvec(3), "R1 p7 z96");    // s = 7
    send(50, 24, 2, mkvec(4), "R3 p50 z24");   // s = 12
  endtask

  task automatic t_scale_mod();
    send(50, 24, 1, mkvec(5), "R2 p50 z24");   // s = 2
    send(95, 96, 1, mkvec(6), "R2 p95 z96");   // s = 95
    send(30, 28, 1, mkvec(7), "R2 p30 z28");   // s = 2
  endtask

  task automatic t_identity();
    send(0, 96, 0, mkvec(8), "R4 z96");
    send(0, 40, 1, mkvec(9), "R4 z40");
  endtask

  task automatic t_null();
    send(-1, 96, 0, mkvec(10), "R5 z96");
    send(-1, 33, 1, mkvec(11), "R5 z33");
  endtask

  task automatic t_upper_lanes();
    logic [DW-1:0] a = mkvec(12);
    logic [DW-1:0] b = a;
    logic [DW-1:0] ra, rb;
    for (int i = 24; i < LANES; i++) b[i*LW +: LW] = 8'hA5;
    send(70, 24, 4, a, "R6 base vector");
    ra = out_vec;
    send(70, 24, 4, b, "R6 garbage above z");
    rb = out_vec;
    chk(ra == rb, "R6", "upper input lanes ignored", rb, ra);
  endtask

  task automatic t_backpressure();
    logic [DW-1:0] va = mkvec(13);
    logic [DW-1:0] vb = mkvec(14);
    logic [DW-1:0] ea = model(40, 48, 0, va);
    logic [DW-1:0] eb = model(40, 48, 1, vb);
    @(negedge clk);
    out_ready = 1'b0;
    in_base = 8'd40; in_z = 7'd48; in_ctype = 3'd0; in_vec = va; in_valid = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7", "ready when empty", DW'(in_ready), DW'(1));
    @(negedge clk);
    in_ctype = 3'd1; in_vec = vb;
    chk(out_valid && out_vec == ea, "R8", "first item out", out_vec, ea);
    chk(in_ready == 1'b0, "R7", "stalled ready low", DW'(in_ready), '0);
    @(negedge clk);
    chk(out_valid && out_vec == ea, "R7", "held under stall", out_vec, ea);
    out_ready = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R7", "ready follows out_ready", DW'(in_ready), DW'(1));
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid && out_vec == eb, "R7", "second item after release", out_vec, eb);
    @(negedge clk);
    chk(out_valid == 1'b0, "R8", "drained", DW'(out_valid), '0);
  endtask

  initial begin
    t_reset();
    t_scale_prop();
    t_scale_mod();
    t_identity();
    t_null();
    t_upper_lanes();
    t_backpressure();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R7 watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule